// File: doc/BRIEF.md
# Dual Reference Monitor and Selector

This block sits in front of a clock-cleaning loop and looks after its two candidate reference inputs. Every signal is sampled on one stable, free-running reference clock. Each input is synchronised and passed through its own prescaler, which produces a one-cycle tick after a chosen number of rising edges. A watchdog per input flags a loss of signal when its ticks stop. The flag is sticky: it clears only after the input has shown a run of well-spaced ticks again.

A manual select line picks which input's ticks feed the loop. The line is filtered so that a short disturbance cannot switch sources. An accepted change takes effect at once, and the loop absorbs whatever phase step results. A three-level output mode either drives the loop's clock out, parks the output, or bypasses the loop and drives the synchronised raw level of the selected input. The prescaler and mode controls arrive already decoded from three-level straps as 2-bit codes: 00 is low, 01 is middle, 10 is high, and 11 is an open pin, treated as middle.

There are no data streams here, so every pin is plain control or status with no handshake. `LOS_TIMEOUT` must be set to no more than 750 µs worth of reference cycles.

Top module: `dual_ref_selector`

## Requirements
- R1: The prescale code sets the ratio per input. Code 00 gives 1, 01 gives 4, 10 gives 32, and 11 gives 4. A tick is produced once per that many synchronised rising edges, so over a steady window the tick count equals the edge count divided by the ratio.
- R2: `loop_tick` carries input A's ticks while `sel_active` is 0 and input B's ticks while it is 1.
- R3: After a 2-stage synchroniser, `sel_b` must differ from `sel_active` for `SEL_HOLD` consecutive reference cycles before `sel_active` takes the new value. A shorter pulse leaves `sel_active` unchanged.
- R4: A loss flag rises after its input has produced no tick for `LOS_TIMEOUT` reference cycles, and not earlier.
- R5: A raised loss flag stays high until its input produces `VALID_N` consecutive tick spacings, each inside [`WIN_LO`, `WIN_HI`] reference cycles. It then clears.
- R6: A tick spacing outside the window, or a timeout, restarts the validation count, so an input running at the wrong rate keeps its flag high.
- R7: Output mode 00 drives the loop clock with `out_oe` high. Mode 10 sets `out_oe` and `out_bypass` and drives the selected raw input. Modes 01 and 11 hold `out_oe`, `out_bypass` and `out_clk` low. The mode takes effect two cycles after it is applied.
- R8: While `rst_n` is low, `out_oe`, `out_bypass`, `out_clk`, `loop_tick` and `sel_active` are 0, and both loss flags are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Free-running reference clock for all logic |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_in_a | input | 1 | Candidate input A, sampled as data |
| clk_in_b | input | 1 | Candidate input B, sampled as data |
| div_a_code | input | 2 | Prescale code for input A |
| div_b_code | input | 2 | Prescale code for input B |
| sel_b | input | 1 | Requested source: 0 for A, 1 for B |
| out_mode | input | 2 | Output path mode code |
| pll_clk | input | 1 | Loop clock, sampled for the enabled output |
| los_a | output | 1 | Sticky loss flag for input A |
| los_b | output | 1 | Sticky loss flag for input B |
| sel_active | output | 1 | Source currently feeding the loop |
| loop_tick | output | 1 | Prescaled tick of the active source |
| out_clk | output | 1 | Output clock level |
| out_oe | output | 1 | Output drive enable; low means tristate |
| out_bypass | output | 1 | High when the loop is bypassed |

## Verification
The assertions assume that each input stays high and low for at least two reference cycles, so the synchroniser sees every edge. They also assume the validation window lies below the timeout. The stimulus keeps to these limits by using half-periods of two reference cycles or longer, with window bounds of 12 to 20 cycles against a 200-cycle timeout. Codes and the select line change only between clock edges. A wrong-rate input is used to show the flag held up by out-of-window spacings.

// File: rtl/refmon_pkg.sv
package refmon_pkg;
  typedef enum logic [1:0] {
    LVL_LO   = 2'b00,
    LVL_MID  = 2'b01,
    LVL_HI   = 2'b10,
    LVL_OPEN = 2'b11
  } lvl_t;

  localparam int unsigned MAX_RATIO = 32;
  localparam int unsigned RCNT_W    = $clog2(MAX_RATIO);

  function automatic int unsigned prediv_ratio(lvl_t code);
    case (code)
      LVL_LO:  return 1;
      LVL_HI:  return MAX_RATIO;
      default: return 4;
    endcase
  endfunction
endpackage

// File: rtl/refmon_prediv.sv
module refmon_prediv
  import refmon_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clk_in,
  input  lvl_t code,
  output logic raw_sync,
  output logic tick
);
  logic [SYNC_STAGES:0] shr;
  logic                 rise;
  logic [RCNT_W-1:0]    cnt;
  logic [RCNT_W-1:0]    last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shr <= '0;
    else        shr <= {shr[SYNC_STAGES-1:0], clk_in};
  end

  assign raw_sync = shr[SYNC_STAGES-1];
  assign rise     = shr[SYNC_STAGES-1] & ~shr[SYNC_STAGES];

  always_comb last = RCNT_W'(prediv_ratio(code) - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else begin
      tick <= 1'b0;
      if (rise) begin
        if (cnt >= last) begin
          cnt  <= '0;
          tick <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R1: a synchronised edge cannot rise on two neighbouring cycles
  p_tick_isolated_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/refmon_los_watch.sv
module refmon_los_watch #(
  parameter int LOS_TIMEOUT = 1000,
  parameter int WIN_LO      = 12,
  parameter int WIN_HI      = 20,
  parameter int VALID_N     = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  output logic los
);
  localparam int GAP_W  = $clog2(LOS_TIMEOUT + 1);
  localparam int GOOD_W = $clog2(VALID_N + 1);
  localparam logic [GAP_W-1:0]  TO_V   = GAP_W'(LOS_TIMEOUT);
  localparam logic [GAP_W:0]    LO_V   = (GAP_W+1)'(WIN_LO);
  localparam logic [GAP_W:0]    HI_V   = (GAP_W+1)'(WIN_HI);
  localparam logic [GOOD_W-1:0] LAST_G = GOOD_W'(VALID_N - 1);

  logic [GAP_W-1:0]  gap;
  logic [GAP_W:0]    span;
  logic              span_ok;
  logic [GOOD_W-1:0] good;

  assign span    = {1'b0, gap} + 1'b1;
  assign span_ok = (span >= LO_V) && (span <= HI_V);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           gap <= '0;
    else if (tick)        gap <= '0;
    else if (gap != TO_V) gap <= gap + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      los  <= 1'b1;
      good <= '0;
    end else if (gap == TO_V) begin
      los  <= 1'b1;
      good <= '0;
    end else if (tick) begin
      if (span_ok) begin
        if (good == LAST_G) begin
          good <= '0;
          los  <= 1'b0;
        end else begin
          good <= good + 1'b1;
        end
      end else begin
        good <= '0;
      end
    end
  end

  // R5: the flag only drops on a tick
  p_clear_on_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(los) |-> $past(tick));
  // R4: the silence counter saturates at the timeout
  p_gap_bounded_r4: assert property (@(posedge clk) disable iff (!rst_n)
    gap <= TO_V);
  // R4: the flag rises only after a full silent timeout
  p_rise_after_silence_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(los) |-> $past(gap) == TO_V);
endmodule

// File: rtl/refmon_sel_filter.sv
module refmon_sel_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int SEL_HOLD    = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_req,
  output logic active
);
  localparam int HCNT_W = $clog2(SEL_HOLD + 1);
  localparam logic [HCNT_W-1:0] HOLD_LAST = HCNT_W'(SEL_HOLD - 1);

  logic [SYNC_STAGES-1:0] shr;
  logic                   req_s;
  logic [HCNT_W-1:0]      cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shr <= '0;
    else        shr <= {shr[SYNC_STAGES-2:0], sel_req};
  end
  assign req_s = shr[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (req_s != active) begin
      if (cnt == HOLD_LAST) begin
        active <= req_s;
        cnt    <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else begin
      cnt <= '0;
    end
  end

  // R3: a switch only lands on the value the synchroniser was presenting
  p_switch_to_request_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(active) |-> $past(req_s) == active);
  // R3: the hold counter never passes its limit
  p_hold_bounded_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= HOLD_LAST);
endmodule

// File: rtl/dual_ref_selector.sv
module dual_ref_selector
  import refmon_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int LOS_TIMEOUT = 1000,
  parameter int WIN_LO      = 12,
  parameter int WIN_HI      = 20,
  parameter int VALID_N     = 3,
  parameter int SEL_HOLD    = 8
) (
  input  logic       ref_clk,
  input  logic       rst_n,
  input  logic       clk_in_a,
  input  logic       clk_in_b,
  input  logic [1:0] div_a_code,
  input  logic [1:0] div_b_code,
  input  logic       sel_b,
  input  logic [1:0] out_mode,
  input  logic       pll_clk,
  output logic       los_a,
  output logic       los_b,
  output logic       sel_active,
  output logic       loop_tick,
  output logic       out_clk,
  output logic       out_oe,
  output logic       out_bypass
);
  localparam int N_IN = 2;

  logic [N_IN-1:0] in_vec;
  logic [N_IN-1:0] raw_s;
  logic [N_IN-1:0] tick_v;
  logic [N_IN-1:0] los_v;
  lvl_t            code_v [N_IN];
  lvl_t            mode_q;

  assign in_vec    = {clk_in_b, clk_in_a};
  assign code_v[0] = lvl_t'(div_a_code);
  assign code_v[1] = lvl_t'(div_b_code);

  for (genvar g = 0; g < N_IN; g++) begin : g_chan
    refmon_prediv #(.SYNC_STAGES(SYNC_STAGES)) u_div (
      .clk      (ref_clk),
      .rst_n    (rst_n),
      .clk_in   (in_vec[g]),
      .code     (code_v[g]),
      .raw_sync (raw_s[g]),
      .tick     (tick_v[g])
    );
    refmon_los_watch #(
      .LOS_TIMEOUT (LOS_TIMEOUT),
      .WIN_LO      (WIN_LO),
      .WIN_HI      (WIN_HI),
      .VALID_N     (VALID_N)
    ) u_los (
      .clk   (ref_clk),
      .rst_n (rst_n),
      .tick  (tick_v[g]),
      .los   (los_v[g])
    );
  end

  refmon_sel_filter #(.SYNC_STAGES(SYNC_STAGES), .SEL_HOLD(SEL_HOLD)) u_sel (
    .clk     (ref_clk),
    .rst_n   (rst_n),
    .sel_req (sel_b),
    .active  (sel_active)
  );

  assign los_a     = los_v[0];
  assign los_b     = los_v[1];
  assign loop_tick = tick_v[sel_active];

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q     <= LVL_MID;
      out_oe     <= 1'b0;
      out_bypass <= 1'b0;
      out_clk    <= 1'b0;
    end else begin
      mode_q <= lvl_t'(out_mode);
      case (mode_q)
        LVL_LO: begin
          out_oe     <= 1'b1;
          out_bypass <= 1'b0;
          out_clk    <= pll_clk;
        end
        LVL_HI: begin
          out_oe     <= 1'b1;
          out_bypass <= 1'b1;
          out_clk    <= raw_s[sel_active];
        end
        default: begin
          out_oe     <= 1'b0;
          out_bypass <= 1'b0;
          out_clk    <= 1'b0;
        end
      endcase
    end
  end

  // R7: a parked output is silent
  p_quiet_when_parked_r7: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !out_oe |-> !out_clk && !out_bypass);
  // R7: middle or open mode parks the output on the next cycle
  p_mid_parks_r7: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (mode_q == LVL_MID || mode_q == LVL_OPEN) |=> !out_oe);
endmodule

// File: tb/sim_dual_ref_selector.sv
`timescale 1ns/1ps
module sim_dual_ref_selector;
  localparam int TO  = 200;
  localparam int LO  = 12;
  localparam int HI  = 20;
  localparam int VN  = 3;
  localparam int HLD = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic in_a = 1'b0, in_b = 1'b0;
  logic [1:0] div_a = 2'b01, div_b = 2'b00, mode = 2'b00;
  logic sel = 1'b0, pll = 1'b0;
  logic los_a, los_b, sel_act, ltick, oclk, oe, byp;

  int checks = 0, errors = 0, cyc = 0;
  int half_a = 2, half_b = 8, ph_a = 0, ph_b = 0, ph_p = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dual_ref_selector #(.LOS_TIMEOUT(TO), .WIN_LO(LO), .WIN_HI(HI),
                      .VALID_N(VN), .SEL_HOLD(HLD)) u0 (
    .ref_clk(clk), .rst_n(rst_n), .clk_in_a(in_a), .clk_in_b(in_b),
    .div_a_code(div_a), .div_b_code(div_b), .sel_b(sel), .out_mode(mode),
    .pll_clk(pll), .los_a(los_a), .los_b(los_b), .sel_active(sel_act),
    .loop_tick(ltick), .out_clk(oclk), .out_oe(oe), .out_bypass(byp));

  // behavioural reference model
  int m_h1[2], m_h2[2], m_h3[2], m_dc[2], m_tk[2], m_gap[2], m_good[2], m_los[2];
  int m_s1, m_s2, m_scnt, m_act, m_mode, m_oe, m_byp, m_clk;

  function automatic int ratio(input logic [1:0] c);
    if (c == 2'b00) return 1;
    if (c == 2'b10) return 32;
    return 4;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < 2; c++) begin
        m_h1[c] = 0; m_h2[c] = 0; m_h3[c] = 0; m_dc[c] = 0;
        m_tk[c] = 0; m_gap[c] = 0; m_good[c] = 0; m_los[c] = 1;
      end
      m_s1 = 0; m_s2 = 0; m_scnt = 0; m_act = 0;
      m_mode = 1; m_oe = 0; m_byp = 0; m_clk = 0;
    end else begin
      m_oe  = (m_mode == 0 || m_mode == 2) ? 1 : 0;
      m_byp = (m_mode == 2) ? 1 : 0;
      m_clk = (m_mode == 2) ? m_h2[m_act] : ((m_mode == 0) ? int'(pll) : 0);
      m_mode = int'(mode);
      if (m_s2 != m_act) begin
        if (m_scnt == HLD - 1) begin m_act = m_s2; m_scnt = 0; end
        else m_scnt++;
      end else m_scnt = 0;
      m_s2 = m_s1; m_s1 = int'(sel);
      for (int c = 0; c < 2; c++) begin
        int n, r, nt, sp;
        n = ratio(c == 0 ? div_a : div_b);
        r = (m_h2[c] == 1 && m_h3[c] == 0) ? 1 : 0;
        if (m_gap[c] == TO) begin m_los[c] = 1; m_good[c] = 0; end
        else if (m_tk[c] == 1) begin
          sp = m_gap[c] + 1;
          if (sp >= LO && sp <= HI) begin
            if (m_good[c] == VN - 1) begin m_good[c] = 0; m_los[c] = 0; end
            else m_good[c]++;
          end else m_good[c] = 0;
        end
        m_gap[c] = (m_tk[c] == 1) ? 0 : ((m_gap[c] == TO) ? TO : m_gap[c] + 1);
        nt = (r == 1 && m_dc[c] >= n - 1) ? 1 : 0;
        if (r == 1) m_dc[c] = (m_dc[c] >= n - 1) ? 0 : m_dc[c] + 1;
        m_tk[c] = nt;
        m_h3[c] = m_h2[c]; m_h2[c] = m_h1[c];
        m_h1[c] = (c == 0) ? int'(in_a) : int'(in_b);
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // per-cycle comparison, then stimulus generation a little after the falling edge
  always @(negedge clk) begin
    if (!done) begin
      chk("R4/R5 los_a", int'(los_a), m_los[0]);
      chk("R4/R5 los_b", int'(los_b), m_los[1]);
      chk("R3 sel_active", int'(sel_act), m_act);
      chk("R1/R2 loop_tick", int'(ltick), m_tk[m_act]);
      chk("R7 out_oe", int'(oe), m_oe);
      chk("R7 out_bypass", int'(byp), m_byp);
      chk("R7 out_clk", int'(oclk), m_clk);
    end
    #1;
    if (half_a > 0) begin ph_a++; if (ph_a >= half_a) begin in_a = ~in_a; ph_a = 0; end end
    if (half_b > 0) begin ph_b++; if (ph_b >= half_b) begin in_b = ~in_b; ph_b = 0; end end
    ph_p++; if (ph_p >= 3) begin pll = ~pll; ph_p = 0; end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 60000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic count_ticks(input int n, output int k);
    k = 0;
    repeat (n) begin step(1); if (ltick) k++; end
  endtask

  initial begin
    int k;
    rst_n = 1'b0;
    step(5);
    // R8: reset values
    chk("R8 reset los_a", int'(los_a), 1);
    chk("R8 reset los_b", int'(los_b), 1);
    chk("R8 reset out_oe", int'(oe), 0);
    chk("R8 reset sel_active", int'(sel_act), 0);
    rst_n = 1'b1;
    step(400);
    chk("R5 los_a cleared after validation", int'(los_a), 0);
    chk("R5 los_b cleared after validation", int'(los_b), 0);
    // R3: short select pulse ignored, held one accepted
    sel = 1'b1; step(3); sel = 1'b0; step(20);
    chk("R3 glitch ignored", int'(sel_act), 0);
    sel = 1'b1; step(20);
    chk("R3 held select accepted", int'(sel_act), 1);
    sel = 1'b0; step(20);
    // R4: loss after silence
    half_b = 0;
    step(TO - 30);
    chk("R4 no early loss", int'(los_b), 0);
    step(40);
    chk("R4 loss raised", int'(los_b), 1);
    // R6: wrong rate keeps the flag up
    half_b = 3; step(300);
    chk("R6 wrong rate stays lost", int'(los_b), 1);
    half_b = 8; step(300);
    chk("R5 good rate revalidates", int'(los_b), 0);
    // R1: ratio 32 then open code as 4
    div_a = 2'b10; step(300);
    count_ticks(640, k);
    chk("R1 ratio 32 tick count", k, 5);
    div_a = 2'b11; step(200);
    count_ticks(160, k);
    chk("R1 open code tick count", k, 10);
    // R7: output modes
    mode = 2'b10; step(10);
    chk("R7 bypass oe", int'(oe), 1);
    chk("R7 bypass flag", int'(byp), 1);
    mode = 2'b01; step(10);
    chk("R7 disabled oe", int'(oe), 0);
    chk("R7 disabled clk", int'(oclk), 0);
    mode = 2'b11; step(10);
    chk("R7 open mode oe", int'(oe), 0);
    // R8: reset mid-run
    rst_n = 1'b0; step(2);
    chk("R8 mid reset oe", int'(oe), 0);
    chk("R8 mid reset los_a", int'(los_a), 1);
    rst_n = 1'b1; step(20);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule